// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. It follows the usual four-wire scheme of clock, mode select, serial data in and serial data out. A 16-state controller is stepped by the mode-select line on each rising test-clock edge. It moves a 3-bit instruction register and one of three data registers between capture, shift and update phases. The three data registers are a 1-bit bypass stage, a 32-bit identification word and a 109-bit boundary chain.

The identification word is assembled from parameters that describe revision, density, data width, clock-alignment circuitry, device type, burst length and I/O style. The boundary chain captures 108 pin values plus one internal control bit, which is the last bit in the chain. That control bit, together with the current instruction, decides whether the device's data outputs are forced to high impedance. The update register drives the captured or loaded pin values out when they are not.

There is no test-reset pin. A synchronous power-up reset, or five test clocks with mode select held high, returns the controller to its reset state and selects the identification instruction.

Top module: `jtag_tap_core`

## Requirements
- R1: After power-up reset the controller is in its reset state, the identification instruction is selected, `tdo_en` is 0, `out_hiz` is 0, the control bit is 0 and `bsr_q` is all zeros.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to its reset state from any state. That state selects the identification instruction (opcode 001).
- R3: During instruction capture the 3-bit instruction shift stage loads 001. Shifting moves bits out least-significant first, with `tdi` entering at the top. The new opcode takes effect on the edge that leaves the instruction-update state.
- R4: The opcodes are:
  - 000: external test
  - 001: identification
  - 010: sample with outputs forced to high impedance
  - 100: sample
  - 111: bypass
  - 011, 101 and 110: treated as bypass
- R5: The identification instruction captures the 32-bit word {revision 000, 00, density 011, 0, width 11, 0, dll 1, 0, quad 0, 0, burst4 1, 0, separate-I/O 0, 0, vendor code 00010100100, 1}, written most-significant first. It is shifted out least-significant first.
- R6: The bypass stage captures 0 and delays `tdi` by one shift cycle. After leaving the shift state it keeps the last bit shifted in.
- R7: With either sample instruction or external test selected, the 109-bit boundary chain captures `pin_in[0..107]` into bits 0..107 and the control bit into bit 108. It shifts out starting with bit 0.
- R8: In the data-update state under sample (100) or external test (000), `bsr_upd` is high for that one cycle. On the edge that leaves that state, `bsr_q` takes chain bits 107..0 and the control bit takes chain bit 108. Under every other instruction, `bsr_q` and the control bit do not change; the control bit is cleared only by the reset state.
- R9: `out_hiz` is 1 under opcode 010. Under opcode 000 it is the inverse of the control bit. Under every other opcode it is 0.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the controller is in the instruction-shift or data-shift state. In those states `tdo` shows the least-significant bit of the selected shift stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_in | input | 108 | Parallel pin values captured into the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Drive enable for `tdo` (1 = drive) |
| out_hiz | output | 1 | Forces the device data outputs to high impedance |
| bsr_upd | output | 1 | One-cycle strobe in the boundary update state |
| bsr_q | output | 108 | Boundary update register driven to the pins |

## Verification
The assertions assume that `tms` and `tdi` settle between edges and are sampled only on rising `tck`. They also assume `rst_n` is held low for at least one rising edge before any operation. The stimulus changes inputs well after the falling edge and before the next rising one, so the rising-edge controller and the falling-edge output stage never see an input move near their edge. The control-bit stability check takes for granted that the instruction can only change through the update state. The bench therefore reaches every new opcode through a complete instruction scan, and it reaches the reset state either through the reset pin or through a run of `tms` high.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, opcodes,
// data-register selection and the controller transition function.
// Assumes a 3-bit instruction register.
package jtag_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST     = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE     = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_HIZ = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b111;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_CHAIN} dr_sel_t;

    // Maps an opcode to the data register placed between tdi and tdo.
    function automatic dr_sel_t decode_dr(logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:                           return DR_IDENT;
            OP_EXTEST, OP_SAMPLE, OP_SAMPLE_HIZ: return DR_CHAIN;
            default:                             return DR_BYPASS;
        endcase
    endfunction

    // Controller transition for one rising tck edge.
    function automatic tap_state_t tap_next(tap_state_t s, logic tms);
        case (s)
            ST_RESET:  return tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
            default:   return tms ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
// 16-state controller stepped by tms on rising tck.
// Assumes rst_n is a synchronous power-up reset; there is no test-reset pin.
module tap_fsm
    import jtag_tap_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    localparam int RUN_W = $clog2(RESET_RUN + 1);

    logic [RUN_W-1:0] high_run;

    // Advance the controller state.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= tap_next(state, tms);
    end

    // Count consecutive tms-high edges, saturating (checker support).
    always_ff @(posedge tck) begin
        if (!rst_n)                           high_run <= '0;
        else if (!tms)                        high_run <= '0;
        else if (high_run != RUN_W'(RESET_RUN)) high_run <= high_run + 1'b1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (high_run == RUN_W'(RESET_RUN)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage and instruction register.
// Assumes the capture pattern is ...001; the reset state selects identification.
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb
);
    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] ir_sh;

    // Capture the fixed pattern, then shift least-significant bit first.
    always_ff @(posedge tck) begin
        if (!rst_n)                  ir_sh <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_sh <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Apply the new opcode on leaving update; the reset state selects identification.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR)     ir_q <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_IR) |=> (ir_sh == CAP_PAT));

    // R2
    reset_selects_id_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
// Data registers: bypass stage, identification shift stage, boundary chain
// with its update register and the internal control bit (last chain bit).
// Assumes the controller state and the data-register selection come from the same opcode.
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          CHAIN_LEN = 109,
    parameter logic [31:0] ID_WORD   = 32'h0000_0001
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  tap_state_t           state,
    input  dr_sel_t              sel,
    input  logic                 upd_ok,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-2:0] pin_in,
    output logic                 dr_lsb,
    output logic                 ctl_bit,
    output logic                 bsr_upd,
    output logic [CHAIN_LEN-2:0] bsr_q
);
    localparam int TOP = CHAIN_LEN - 1;

    logic              byp;
    logic [31:0]       id_sh;
    logic [TOP:0]      chain_sh;

    assign bsr_upd = (state == ST_UPD_DR) && upd_ok;

    // Bypass stage: captures 0, otherwise follows tdi while shifting.
    always_ff @(posedge tck) begin
        if (!rst_n)                                     byp <= 1'b0;
        else if (state == ST_CAP_DR)                    byp <= 1'b0;
        else if (state == ST_SH_DR && sel == DR_BYPASS) byp <= tdi;
    end

    // Identification stage: loads the fixed word and shifts it out.
    always_ff @(posedge tck) begin
        if (!rst_n)                                    id_sh <= '0;
        else if (state == ST_CAP_DR)                   id_sh <= ID_WORD;
        else if (state == ST_SH_DR && sel == DR_IDENT) id_sh <= {tdi, id_sh[31:1]};
    end

    // Boundary chain: captures pins and the control bit, then shifts.
    always_ff @(posedge tck) begin
        if (!rst_n)                                    chain_sh <= '0;
        else if (state == ST_CAP_DR)                   chain_sh <= {ctl_bit, pin_in};
        else if (state == ST_SH_DR && sel == DR_CHAIN) chain_sh <= {tdi, chain_sh[TOP:1]};
    end

    // Update register and control bit: load on update under the allowed opcodes.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ctl_bit <= 1'b0;
            bsr_q   <= '0;
        end else if (state == ST_RESET) begin
            ctl_bit <= 1'b0;
        end else if (bsr_upd) begin
            ctl_bit <= chain_sh[TOP];
            bsr_q   <= chain_sh[TOP-1:0];
        end
    end

    // Least-significant bit of the selected stage.
    always_comb begin
        case (sel)
            DR_IDENT: dr_lsb = id_sh[0];
            DR_CHAIN: dr_lsb = chain_sh[0];
            default:  dr_lsb = byp;
        endcase
    end

    // R6
    bypass_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR) |=> (byp == 1'b0));

    // R8
    ctl_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (!upd_ok && state != ST_RESET) |=> $stable(ctl_bit));

    // R8
    upd_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !bsr_upd |=> $stable(bsr_q));

endmodule

// File: rtl/jtag_tap_core.sv
// Top of the test access port: assembles the identification word,
// selects the data register, times tdo on the falling edge and forms the
// output high-impedance override.
// Assumes tms/tdi are stable around rising tck and rst_n is synchronous.
module jtag_tap_core
    import jtag_tap_pkg::*;
#(
    parameter int         CHAIN_LEN    = 109,
    parameter logic [2:0] REVISION     = 3'b000,
    parameter logic [2:0] DENSITY_CODE = 3'b011,
    parameter logic [1:0] WIDTH_CODE   = 2'b11,
    parameter logic       HAS_DLL      = 1'b1,
    parameter logic       IS_QUAD      = 1'b0,
    parameter logic       BURST4       = 1'b1,
    parameter logic       SEP_IO       = 1'b0,
    parameter logic [10:0] VENDOR      = 11'b00010100100
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-2:0] pin_in,
    output logic                 tdo,
    output logic                 tdo_en,
    output logic                 out_hiz,
    output logic                 bsr_upd,
    output logic [CHAIN_LEN-2:0] bsr_q
);
    localparam logic [16:0] CFG_FIELD = {2'b00, DENSITY_CODE, 1'b0, WIDTH_CODE,
                                         1'b0, HAS_DLL, 1'b0, IS_QUAD, 1'b0,
                                         BURST4, 1'b0, SEP_IO, 1'b0};
    localparam logic [31:0] ID_WORD   = {REVISION, CFG_FIELD, VENDOR, 1'b1};

    tap_state_t      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            dr_lsb;
    logic            ctl_bit;
    dr_sel_t         sel;
    logic            upd_ok;
    logic            shifting;

    tap_fsm #(.RESET_RUN(5)) u_fsm (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
    );

    tap_ir u_ir (
        .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
        .ir_q(ir_q), .ir_lsb(ir_lsb)
    );

    assign sel    = decode_dr(ir_q);
    assign upd_ok = (ir_q == OP_SAMPLE) || (ir_q == OP_EXTEST);

    tap_dr #(.CHAIN_LEN(CHAIN_LEN), .ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .rst_n(rst_n), .state(state), .sel(sel), .upd_ok(upd_ok),
        .tdi(tdi), .pin_in(pin_in), .dr_lsb(dr_lsb), .ctl_bit(ctl_bit),
        .bsr_upd(bsr_upd), .bsr_q(bsr_q)
    );

    // Output override: forced under sample-hiz, control-bit gated under external test.
    always_comb begin
        case (ir_q)
            OP_SAMPLE_HIZ: out_hiz = 1'b1;
            OP_EXTEST:     out_hiz = !ctl_bit;
            default:       out_hiz = 1'b0;
        endcase
    end

    assign shifting = (state == ST_SH_IR) || (state == ST_SH_DR);

    // Serial output stage, retimed to the falling edge of tck.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shifting;
            if (state == ST_SH_IR)      tdo <= ir_lsb;
            else if (state == ST_SH_DR) tdo <= dr_lsb;
        end
    end

    // R10
    tdo_en_state_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> shifting);

endmodule

// File: tb/jtag_tap_core_test.sv
`timescale 1ns/1ps
module jtag_tap_core_test;
    localparam int  NB = 108;
    localparam int  S_RST = 0, S_IDL = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5,
                    S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11,
                    S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;
    localparam logic [31:0] EXP_ID = {3'b000, 2'b00, 3'b011, 1'b0, 2'b11, 1'b0, 1'b1,
                                      1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                                      11'b00010100100, 1'b1};

    logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [NB-1:0] pin_in = '0;
    logic tdo, tdo_en, out_hiz, bsr_upd;
    logic [NB-1:0] bsr_q;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string cur = "R1";

    // reference model state
    int m_st;
    logic m_irq[$];
    logic m_drq[$];
    logic [2:0] m_ir;
    logic m_ctl;
    logic [NB-1:0] m_upd;
    logic m_tdo;

    jtag_tap_core uut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz), .bsr_upd(bsr_upd), .bsr_q(bsr_q)
    );

    always #2.5 tck = ~tck;

    function automatic int nxt(int s, logic t);
        case (s)
            S_RST: return t ? S_RST : S_IDL;
            S_IDL: return t ? S_SDR : S_IDL;
            S_SDR: return t ? S_SIR : S_CDR;
            S_CDR, S_HDR: return t ? S_E1D : S_HDR;
            S_E1D: return t ? S_UDR : S_PDR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_E2D: return t ? S_UDR : S_HDR;
            S_UDR, S_UIR: return t ? S_SDR : S_IDL;
            S_SIR: return t ? S_RST : S_CIR;
            S_CIR, S_HIR: return t ? S_E1I : S_HIR;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PIR: return t ? S_E2I : S_PIR;
            default: return t ? S_UIR : S_HIR;
        endcase
    endfunction

    function automatic int dsel(logic [2:0] op);
        if (op == 3'b001) return 1;
        if (op == 3'b000 || op == 3'b100 || op == 3'b010) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        m_st = S_RST; m_irq = '{1'b1, 1'b0, 1'b0}; m_drq.delete();
        m_ir = 3'b001; m_ctl = 1'b0; m_upd = '0; m_tdo = 1'b0;
    endtask

    task automatic model_edge(logic t, logic d);
        case (m_st)
            S_RST: begin m_ir = 3'b001; m_ctl = 1'b0; end
            S_CIR: m_irq = '{1'b1, 1'b0, 1'b0};
            S_HIR: begin void'(m_irq.pop_front()); m_irq.push_back(d); end
            S_UIR: m_ir = {m_irq[2], m_irq[1], m_irq[0]};
            S_CDR: begin
                m_drq.delete();
                case (dsel(m_ir))
                    1: for (int i = 0; i < 32; i++) m_drq.push_back(EXP_ID[i]);
                    2: begin
                        for (int i = 0; i < NB; i++) m_drq.push_back(pin_in[i]);
                        m_drq.push_back(m_ctl);
                    end
                    default: m_drq.push_back(1'b0);
                endcase
            end
            S_HDR: begin void'(m_drq.pop_front()); m_drq.push_back(d); end
            S_UDR: if (m_ir == 3'b100 || m_ir == 3'b000) begin
                for (int i = 0; i < NB; i++) m_upd[i] = m_drq[i];
                m_ctl = m_drq[NB];
            end
            default: ;
        endcase
        m_st = nxt(m_st, t);
        if (m_st == S_HIR) m_tdo = m_irq[0];
        if (m_st == S_HDR) m_tdo = m_drq[0];
    endtask

    task automatic chk(string req, string what, logic [NB-1:0] act, logic [NB-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic en_e, hz_e, up_e;
        en_e = (m_st == S_HIR || m_st == S_HDR);
        hz_e = (m_ir == 3'b010) ? 1'b1 : (m_ir == 3'b000) ? !m_ctl : 1'b0;
        up_e = (m_st == S_UDR) && (m_ir == 3'b100 || m_ir == 3'b000);
        chk("R10", "tdo_en", NB'(tdo_en), NB'(en_e));
        chk("R9", "out_hiz", NB'(out_hiz), NB'(hz_e));
        chk("R8", "bsr_upd", NB'(bsr_upd), NB'(up_e));
        chk("R8", "bsr_q", bsr_q, m_upd);
        if (en_e) chk(cur, "tdo", NB'(tdo), NB'(m_tdo));
    endtask

    // one tck cycle: drive, rising edge, model, sample near end of cycle
    task automatic step(logic t, logic d);
        tms = t; tdi = d;
        @(posedge tck);
        model_edge(t, d);
        #4;
        compare_all();
    endtask

    task automatic load_ir(logic [2:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(0, op[0]); step(0, op[1]); step(1, op[2]);
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(int n, logic [127:0] d);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
        step(1, 0); step(0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat;
        model_reset();
        repeat (3) @(posedge tck);
        #4;
        rst_n = 1'b1;
        // R1: reset state at the ports
        cur = "R1";
        chk("R1", "tdo_en", NB'(tdo_en), NB'(0));
        chk("R1", "out_hiz", NB'(out_hiz), NB'(0));
        chk("R1", "bsr_q", bsr_q, '0);
        step(0, 0);
        // R5: identification word right after reset
        cur = "R5";
        scan_dr(32, 128'h0);
        // R3: instruction capture pattern observed while loading bypass
        cur = "R3";
        load_ir(3'b111);
        // R6: bypass delay
        cur = "R6";
        scan_dr(10, 128'h2D3);
        scan_dr(4, 128'h0);
        // R4: reserved opcodes behave as bypass
        cur = "R4";
        load_ir(3'b101);
        scan_dr(6, 128'h2B);
        load_ir(3'b011);
        scan_dr(6, 128'h15);
        load_ir(3'b110);
        scan_dr(3, 128'h5);
        // R7: sample captures pins, loads control bit high
        cur = "R7";
        pin_in = {12'hA5C, 32'hDEADBEEF, 32'h12345678, 32'h0F0F3C3C};
        load_ir(3'b100);
        pat = {19'h0, 1'b1, 12'h3C1, 32'hCAFEF00D, 32'h89ABCDEF, 32'h55AA33CC};
        scan_dr(109, pat);
        // R9: external test with control bit set drives outputs
        cur = "R9";
        pin_in = {12'h123, 32'h01234567, 32'hFEDCBA98, 32'h76543210};
        load_ir(3'b000);
        cur = "R7";
        pat = {19'h0, 1'b0, 12'hFFF, 32'h0, 32'hFFFF0000, 32'h13579BDF};
        scan_dr(109, pat);
        // R8: sample-hiz does not update bsr_q or the control bit
        cur = "R8";
        load_ir(3'b010);
        pat = {19'h0, 1'b1, 12'h000, 32'h11111111, 32'h22222222, 32'h33333333};
        scan_dr(109, pat);
        load_ir(3'b000);
        // R8: bypass does not update either
        load_ir(3'b111);
        scan_dr(5, 128'h1F);
        // R2: five tms-high cycles from the middle of a shift
        cur = "R2";
        load_ir(3'b100);
        step(1, 0); step(0, 0); step(0, 1); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        chk("R2", "out_hiz after run", NB'(out_hiz), NB'(0));
        step(0, 0);
        scan_dr(32, 128'hFFFF);
        // R2: run from instruction shift as well
        step(1, 0); step(1, 0); step(0, 0); step(0, 1);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        cur = "R5";
        scan_dr(32, 128'h0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule